// File: doc/BRIEF.md
# Saturating Score-to-Pulse-Width Converter

This block turns a signed digital attention score into a single output pulse whose length follows a hard-sigmoid curve. The length is counted in cycles of a 1 GHz clock, so one cycle is one nanosecond. A non-positive score gives no pulse. A score at or above a programmable saturation threshold gives the full 15-cycle pulse. A score between the two gives a length that grows linearly with the score. The pulse feeds the next dot-product stage as a pulse-width-coded operand.

A caller applies a score and a threshold and strobes start for one cycle. The pulse begins on the following cycle. A one-cycle done flag marks its end, or marks a zero-length result straight away. While a pulse is running the converter is busy, and it disregards further start strobes.

Top module: `score_pulse_gen`

## Requirements
- R1: After synchronous reset, pulse_o and done_o are both low.
- R2: A score of zero or below (score_i is two's complement) gives a width of 0 cycles. pulse_o stays low, and done_o is high in the cycle right after the start cycle.
- R3: With a nonzero threshold, a score greater than or equal to thr_i gives the full width of 15 cycles.
- R4: For 0 < score < thr_i, the width is floor(score * 15 / thr_i) cycles.
- R5: With thr_i equal to zero, any positive score gives the full width of 15 cycles.
- R6: For a width W > 0, pulse_o rises in the cycle after the start cycle and stays high for exactly W consecutive cycles.
- R7: done_o is high for the single cycle after the last high cycle of pulse_o, and is never high together with pulse_o.
- R8: A start strobe seen while pulse_o is high is ignored. The running pulse keeps its length, and its done timing does not change.
- R9: A start strobe in the cycle where done_o is high is accepted, so pulses can follow one another with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pulse clock (1 GHz in the target system) |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request to convert the present score |
| score_i | input | SCORE_W | Signed score, two's complement |
| thr_i | input | THR_W | Unsigned saturation threshold; 0 means saturate on any positive score |
| pulse_o | output | 1 | Pulse, high for the computed number of cycles |
| done_o | output | 1 | One-cycle end-of-conversion flag |

## Verification
The assertions assume that score_i and thr_i are stable in the cycle where start_i is accepted. Only those values are sampled. The counter checks also assume that reset is held long enough for the first clock edge to clear the state. The bench changes score and threshold only at the falling clock edge, together with start. It holds start for exactly one cycle, except in the deliberate overlap tests, where start is raised in the middle of a pulse to show that it has no effect.

// File: rtl/spw_pkg.sv
package spw_pkg;
    // Longest pulse in cycles (15 ns at 1 GHz)
    localparam int SPW_MAX_CYC = 15;
    localparam int SPW_CNT_W   = $clog2(SPW_MAX_CYC + 1);

    typedef enum logic [1:0] {
        RG_ZERO,
        RG_LINEAR,
        RG_SAT
    } spw_region_e;

    typedef enum logic {
        PH_IDLE,
        PH_HIGH
    } spw_phase_e;

    typedef struct packed {
        spw_phase_e             phase;
        logic [SPW_CNT_W-1:0]   left;
        logic                   done;
    } spw_state_t;
endpackage

// File: rtl/spw_width_calc.sv
module spw_width_calc
    import spw_pkg::*;
#(
    parameter int SCORE_W = 16,
    parameter int THR_W   = 16
) (
    input  logic signed [SCORE_W-1:0] score_i,
    input  logic [THR_W-1:0]          thr_i,
    output spw_region_e               region_o,
    output logic [SPW_CNT_W-1:0]      width_o
);
    localparam int MAG_W  = SCORE_W - 1;
    localparam int CMP_W  = (MAG_W > THR_W) ? MAG_W : THR_W;
    localparam int PROD_W = CMP_W + SPW_CNT_W;

    logic [CMP_W-1:0]  mag_x;
    logic [CMP_W-1:0]  thr_x;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;
    logic              neg;

    always_comb begin
        neg    = score_i[SCORE_W-1];
        mag_x  = CMP_W'(score_i[MAG_W-1:0]);
        thr_x  = CMP_W'(thr_i);
        prod   = PROD_W'(mag_x) * PROD_W'(SPW_MAX_CYC);
        quot   = '0;
        region_o = RG_LINEAR;
        if (neg || (mag_x == '0)) begin
            region_o = RG_ZERO;
        end else if ((thr_x == '0) || (mag_x >= thr_x)) begin
            region_o = RG_SAT;
        end else begin
            quot = prod / PROD_W'(thr_x);
        end

        unique case (region_o)
            RG_ZERO:   width_o = '0;
            RG_SAT:    width_o = SPW_CNT_W'(SPW_MAX_CYC);
            default:   width_o = SPW_CNT_W'(quot);
        endcase
    end
endmodule

// File: rtl/spw_pulse_timer.sv
module spw_pulse_timer
    import spw_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  start_i,
    input  logic [SPW_CNT_W-1:0]  width_i,
    output logic                  pulse_o,
    output logic                  done_o
);
    spw_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.phase == PH_HIGH) begin
            // start ignored while the pulse runs
            st_d.left = st_q.left - 1'b1;
            if (st_q.left == SPW_CNT_W'(1)) begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
            end
        end else if (start_i) begin
            if (width_i == '0) begin
                st_d.done = 1'b1;
            end else begin
                st_d.phase = PH_HIGH;
                st_d.left  = width_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '{phase: PH_IDLE, left: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = (st_q.phase == PH_HIGH);
    assign done_o  = st_q.done;

    AST_LEFT_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |-> (st_q.left != '0) && (st_q.left <= SPW_CNT_W'(SPW_MAX_CYC))); // R6
    AST_IGNORE_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
        (pulse_o && st_q.left > SPW_CNT_W'(1)) |=> pulse_o && (st_q.left == $past(st_q.left) - 1'b1)); // R8
    AST_END_DONE: assert property (@(posedge clk_i) disable iff (rst_i)
        (pulse_o && st_q.left == SPW_CNT_W'(1)) |=> done_o && !pulse_o); // R7
endmodule

// File: rtl/score_pulse_gen.sv
module score_pulse_gen
    import spw_pkg::*;
#(
    parameter int SCORE_W = 16,
    parameter int THR_W   = 16
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      start_i,
    input  logic signed [SCORE_W-1:0] score_i,
    input  logic [THR_W-1:0]          thr_i,
    output logic                      pulse_o,
    output logic                      done_o
);
    spw_region_e          region;
    logic [SPW_CNT_W-1:0] width;

    spw_width_calc #(
        .SCORE_W (SCORE_W),
        .THR_W   (THR_W)
    ) i_calc (
        .score_i  (score_i),
        .thr_i    (thr_i),
        .region_o (region),
        .width_o  (width)
    );

    spw_pulse_timer i_timer (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (start_i),
        .width_i (width),
        .pulse_o (pulse_o),
        .done_o  (done_o)
    );

    AST_NOT_BOTH: assert property (@(posedge clk_i) disable iff (rst_i)
        !(pulse_o && done_o)); // R7
    AST_ZERO_DONE: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && !pulse_o && score_i <= 0) |=> done_o && !pulse_o); // R2
    AST_SAT_FULL: assert property (@(posedge clk_i) disable iff (rst_i)
        (score_i > 0 && SCORE_W'(thr_i) <= score_i) |-> region == RG_SAT && width == SPW_CNT_W'(SPW_MAX_CYC)); // R3
    AST_RISE_NEXT: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && !pulse_o && score_i > 0 && thr_i == '0) |=> $rose(pulse_o)); // R5
    AST_FALL_DONE: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(pulse_o) |-> done_o); // R7
endmodule

// File: tb/test_score_pulse_gen.sv
module test_score_pulse_gen;
    localparam int SW = 16;
    localparam int TW = 16;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 start = 1'b0;
    logic signed [SW-1:0] score = '0;
    logic [TW-1:0]        thr = '0;
    logic                 pulse, done;

    int total = 0;
    int bad   = 0;
    bit timed_out = 1'b0;

    always #4 clk = ~clk;

    score_pulse_gen #(.SCORE_W(SW), .THR_W(TW)) i_score_pulse_gen (
        .clk_i(clk), .rst_i(rst), .start_i(start), .score_i(score),
        .thr_i(thr), .pulse_o(pulse), .done_o(done)
    );

    function automatic int exp_width(int s, int t);
        if (s <= 0) return 0;
        if (t == 0 || s >= t) return 15;
        return (s * 15) / t;
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; strobes start for one cycle and measures the pulse.
    // interfere: raise start again a few cycles into the pulse (R8).
    // gap: check that done drops next cycle (skip for back-to-back, R9).
    task automatic run_pulse(int s, int t, string req, bit interfere, bit gap);
        int w = exp_width(s, t);
        int cnt = 0;
        score = SW'(s);
        thr   = TW'(t);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (w == 0) check({req, " R2 no pulse"}, int'(pulse), 0);
        else        check({req, " R6 rise"}, int'(pulse), 1);
        while (pulse && cnt < 40) begin
            cnt++;
            if (interfere && cnt == 3) begin
                start = 1'b1;
                score = -SW'(7);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check({req, " width"}, cnt, w);
        check({req, " R7 done"}, int'(done), 1);
        if (gap) begin
            @(negedge clk);
            check({req, " R7 done one cycle"}, int'(done), 0);
        end
    endtask

    initial begin
        #1500000;
        timed_out = 1'b1;
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250911));
        repeat (3) @(negedge clk);
        check("R1 pulse reset", int'(pulse), 0);
        check("R1 done reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);

        run_pulse(0, 100, "R2 zero", 0, 1);
        run_pulse(-300, 100, "R2 negative", 0, 1);
        run_pulse(-32768, 5, "R2 most negative", 0, 1);
        run_pulse(100, 100, "R3 equal", 0, 1);
        run_pulse(32767, 9, "R3 above", 0, 1);
        run_pulse(50, 100, "R4 half", 0, 1);
        run_pulse(99, 100, "R4 just below", 0, 1);
        run_pulse(6, 100, "R4 truncate to zero", 0, 1);
        run_pulse(7, 100, "R4 one cycle", 0, 1);
        run_pulse(1, 0, "R5 zero thr", 0, 1);
        run_pulse(80, 100, "R8 overlap", 1, 1);
        run_pulse(200, 100, "R8 overlap full", 1, 1);
        run_pulse(40, 60, "R9 first", 0, 0);
        run_pulse(0, 60, "R9 second zero", 0, 0);
        run_pulse(60, 60, "R9 third", 0, 1);

        for (int i = 0; i < 250; i++) begin
            int t, s;
            t = int'($urandom_range(0, 2000));
            case ($urandom_range(0, 3))
                0: s = -int'($urandom_range(0, 32768));
                1: s = t + int'($urandom_range(0, 30));
                default: s = int'($urandom_range(1, 2100));
            endcase
            if (s > 32767) s = 32767;
            run_pulse(s, t, "R4 random", ($urandom_range(0, 7) == 0), ($urandom_range(0, 1) == 1));
        end

        if (!timed_out) begin
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule